// File: doc/BRIEF.md
# I2C Interrupt Status and Clear Unit

This unit is the interrupt register bank of an I2C master controller. Twelve event sources coming from the controller core are gathered into a raw status word. A programmable mask is applied to that word to form the masked status, and a single interrupt line is raised whenever any masked bit is set. Ten of the sources are sticky: a one-cycle pulse sets the bit, and the bit stays set until software clears it. The receive-threshold source and the transmit-threshold source are not latched. They follow level inputs driven by the FIFO thresholds.

Software clears a sticky event by reading that event's own clear address. A separate clear address clears every sticky event at once. A transmit abort also leaves behind a cause vector. That vector accumulates until the abort clear (or the combined clear) is read. Software must therefore read the cause vector first and clear the abort event afterwards.

Register map (word addresses, 16-bit read data):

| Address | Access | Name | Meaning |
|---|---|---|---|
| 0x00 | read | raw status | Raw status word |
| 0x01 | read | masked status | Raw status AND mask |
| 0x02 | read/write | mask | Interrupt mask |
| 0x03 | read | abort cause | Abort-cause vector |
| 0x04 | read | combined clear | Clears all sticky events and the abort cause |
| 0x10 + i | read | event clear | Clears event i |

Top module: `irq_status_unit`

## Requirements
- R1: After synchronous reset, the raw status reads 0x000, the mask reads 0xFFF, the abort cause reads 0x0000 and irq is low.
- R2: For a sticky source, a pulse on evt_pulse[i] sets raw status bit i at the next clock edge, and the bit stays set until it is cleared. The raw status bit positions are: 0 receive underflow, 1 receive overflow, 2 receive threshold, 3 transmit overflow, 4 transmit threshold, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen, 11 general call.
- R3: A read at 0x01 returns the raw status AND the mask, and irq is high exactly when that value is non-zero.
- R4: A read at address 0x10+i clears only sticky bit i, at the clock edge that ends the read. The read itself returns zero.
- R5: A read at 0x04 clears every sticky bit and the abort-cause vector at once.
- R6: Bits 2 and 4 follow evt_pulse[2] and evt_pulse[4] in the same cycle. No clear read (0x12, 0x14 or 0x04) has any effect on them.
- R7: Each cycle, the abort-cause register ORs in abort_cause_in, but only at the defined positions 0,1,2,3,4,5,7,9,10,11 (mask 0x0EBF). The other bits always read zero. The register is cleared only by a read at 0x16 (transmit-abort clear) or at 0x04.
- R8: An event pulse, or an abort-cause bit, that arrives in the same cycle as a clear read of that bit leaves the bit set.
- R9: A write to 0x02 loads the low 12 bits of reg_wdata into the mask. A mask of zero holds irq low and leaves the raw status unchanged.
- R10: A read of any address outside the map returns zero and changes no state. reg_rdata is zero when reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register word address |
| reg_rd | input | 1 | Read strobe; a read at a clear address clears state at this edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle reg_rd is high |
| evt_pulse | input | 12 | Event inputs: pulses for sticky bits, levels for bits 2 and 4 |
| abort_cause_in | input | 16 | Abort-cause bits to capture this cycle |
| irq | output | 1 | Interrupt line |

## Verification
The bound checker watches several behaviours on every cycle. It checks that a sticky event, once pulsed, is set on the next edge even when a clear is also being read. It checks that a dedicated clear read drops exactly one sticky bit and no other. It checks that the abort-cause vector never loses a bit except on one of its two clear reads, that a zero mask keeps irq low, and the state just after reset. Some behaviours can only be shown by the bench's scenarios. These include the exact value returned at each address, the full sweep of all 4096 mask values against a fixed status pattern, and the level-following bits ignoring their clear addresses. They also include the filtering of undefined abort-cause positions and the combined clear wiping both the status and the cause vector.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int NUM_EVT = 12;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int CAUSE_W = 16;

    // event bit positions
    localparam int EV_RX_UNDER  = 0;
    localparam int EV_RX_OVER   = 1;
    localparam int EV_RX_THRESH = 2;
    localparam int EV_TX_OVER   = 3;
    localparam int EV_TX_THRESH = 4;
    localparam int EV_RD_REQ    = 5;
    localparam int EV_TX_ABORT  = 6;
    localparam int EV_RX_DONE   = 7;
    localparam int EV_ACTIVITY  = 8;
    localparam int EV_STOP_SEEN = 9;
    localparam int EV_STRT_SEEN = 10;
    localparam int EV_GEN_CALL  = 11;

    // sources that follow a level instead of latching a pulse
    localparam logic [NUM_EVT-1:0] LEVEL_SRC =
        NUM_EVT'((1 << EV_RX_THRESH) | (1 << EV_TX_THRESH));

    // defined abort-cause positions
    localparam logic [CAUSE_W-1:0] CAUSE_VALID = 16'h0EBF;

    typedef enum logic [ADDR_W-1:0] {
        RA_RAW     = 5'h00,
        RA_MASKED  = 5'h01,
        RA_MASK    = 5'h02,
        RA_CAUSE   = 5'h03,
        RA_CLR_ALL = 5'h04
    } reg_addr_e;

    // clear addresses: CLR_BASE + event index
    localparam logic [ADDR_W-1:0] CLR_BASE = 5'h10;

    typedef struct packed {
        logic               clr_all;
        logic [NUM_EVT-1:0] clr_one;
        logic               mask_we;
    } reg_ctl_t;

    function automatic logic is_clear_addr(logic [ADDR_W-1:0] a, int idx);
        return a == (CLR_BASE + ADDR_W'(idx));
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_status_pkg::*;
#(
    parameter int N_EVT = NUM_EVT,
    parameter int AW    = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output reg_ctl_t      ctl
);
    always_comb begin
        ctl         = '0;
        ctl.clr_all = rd && (addr == RA_CLR_ALL);
        ctl.mask_we = wr && (addr == RA_MASK);
        for (int i = 0; i < N_EVT; i++) begin
            ctl.clr_one[i] = rd && is_clear_addr(addr, i);
        end
    end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int                 N_EVT  = 12,
    parameter logic [N_EVT-1:0]   LEVELS = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] evt_in,
    input  logic [N_EVT-1:0] clr_one,
    input  logic             clr_all,
    output logic [N_EVT-1:0] raw
);
    for (genvar i = 0; i < N_EVT; i++) begin : g_src
        if (LEVELS[i]) begin : g_level
            assign raw[i] = evt_in[i];
        end else begin : g_sticky
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (evt_in[i])
                    bit_q <= 1'b1;          // set wins over a clear
                else if (clr_one[i] || clr_all)
                    bit_q <= 1'b0;
            end
            assign raw[i] = bit_q;
        end
    end
endmodule

// File: rtl/irq_abort_cap.sv
module irq_abort_cap #(
    parameter int               W     = 16,
    parameter logic [W-1:0]     VALID = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cause_in,
    input  logic         clr,
    output logic [W-1:0] cause_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cause_q <= '0;
        else
            cause_q <= (clr ? '0 : cause_q) | (cause_in & VALID);
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int N_EVT = NUM_EVT,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int CW    = CAUSE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [N_EVT-1:0] evt_pulse,
    input  logic [CW-1:0] abort_cause_in,
    output logic          irq
);
    localparam int PAD = DW - N_EVT;

    reg_ctl_t          ctl;
    logic [N_EVT-1:0]  raw_stat;
    logic [N_EVT-1:0]  mask_q;
    logic [N_EVT-1:0]  masked;
    logic [CW-1:0]     abort_q;

    irq_reg_decode #(.N_EVT(N_EVT), .AW(AW)) u_dec (
        .addr (reg_addr),
        .rd   (reg_rd),
        .wr   (reg_wr),
        .ctl  (ctl)
    );

    irq_src_bank #(.N_EVT(N_EVT), .LEVELS(LEVEL_SRC)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .evt_in  (evt_pulse),
        .clr_one (ctl.clr_one),
        .clr_all (ctl.clr_all),
        .raw     (raw_stat)
    );

    irq_abort_cap #(.W(CW), .VALID(CAUSE_VALID)) u_cause (
        .clk      (clk),
        .rst      (rst),
        .cause_in (abort_cause_in),
        .clr      (ctl.clr_one[EV_TX_ABORT] || ctl.clr_all),
        .cause_q  (abort_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '1;
        else if (ctl.mask_we)
            mask_q <= reg_wdata[N_EVT-1:0];
    end

    assign masked = raw_stat & mask_q;
    assign irq    = |masked;

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                RA_RAW:    reg_rdata = {{PAD{1'b0}}, raw_stat};
                RA_MASKED: reg_rdata = {{PAD{1'b0}}, masked};
                RA_MASK:   reg_rdata = {{PAD{1'b0}}, mask_q};
                RA_CAUSE:  reg_rdata = DW'(abort_q);
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_status_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_rd,
    input logic [NUM_EVT-1:0] evt_pulse,
    input logic               irq,
    input logic [NUM_EVT-1:0] raw,
    input logic [NUM_EVT-1:0] mask,
    input logic [CAUSE_W-1:0] abort_q
);
    localparam logic [NUM_EVT-1:0] STICKY = ~LEVEL_SRC;
    localparam logic [ADDR_W-1:0]  ABT_CLR = CLR_BASE + ADDR_W'(EV_TX_ABORT);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == '1 && (raw & STICKY) == '0 && abort_q == '0)); // R1

    AST_PULSE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse & STICKY) != '0 |=>
        ((raw & $past(evt_pulse & STICKY)) == $past(evt_pulse & STICKY))); // R8

    AST_CLEAR_ONE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr[ADDR_W-1] && evt_pulse == '0) |=>
        ((raw & STICKY) ==
         ($past(raw) & STICKY & ~(NUM_EVT'(1) << $past(reg_addr[ADDR_W-2:0]))))); // R4

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && (reg_addr == ABT_CLR || reg_addr == RA_CLR_ALL)) |=>
        (($past(abort_q) & ~abort_q) == '0)); // R7

    AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        mask == '0 |-> !irq); // R9

    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
        irq |-> (raw != '0)); // R3
endmodule

bind irq_status_unit irq_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .evt_pulse (evt_pulse),
    .irq       (irq),
    .raw       (raw_stat),
    .mask      (mask_q),
    .abort_q   (abort_q)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [11:0] evt_pulse = '0;
    logic [15:0] abort_cause_in = '0;
    logic        irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    logic [15:0] rd_s;
    logic        irq_s;

    localparam logic [11:0] STICKY = 12'hFEB;
    localparam logic [15:0] VALID  = 16'h0EBF;

    always #10 clk = ~clk;   // 50 MHz

    irq_status_unit i_irq_status_unit (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .abort_cause_in(abort_cause_in), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // one clock cycle, entered and left just after a falling edge
    task automatic cyc(input logic [4:0] a, input logic rd, input logic wr,
                       input logic [15:0] wd, input logic [11:0] ev,
                       input logic [15:0] cause);
        reg_addr = a; reg_rd = rd; reg_wr = wr; reg_wdata = wd;
        evt_pulse = ev; abort_cause_in = cause;
        #1;
        rd_s  = reg_rdata;
        irq_s = irq;
        @(negedge clk);
        reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        evt_pulse = '0; abort_cause_in = '0;
    endtask

    task automatic rd(input logic [4:0] a);
        cyc(a, 1'b1, 1'b0, 16'h0, 12'h0, 16'h0);
    endtask

    task automatic wr_mask(input logic [15:0] d);
        cyc(5'h02, 1'b0, 1'b1, d, 12'h0, 16'h0);
    endtask

    task automatic pulse(input logic [11:0] ev);
        cyc(5'h00, 1'b0, 1'b0, 16'h0, ev, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0x0000 expected 0x0001");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] exp_raw;
        logic [15:0] exp_c;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h00); check("R1 raw", rd_s, 16'h0000);
        check("R1 irq", {15'h0, irq_s}, 16'h0);
        rd(5'h02); check("R1 mask", rd_s, 16'h0FFF);
        rd(5'h03); check("R1 cause", rd_s, 16'h0000);

        // R2/R3/R4 per-bit set then dedicated clear
        for (int i = 0; i < 12; i++) begin
            if (STICKY[i]) begin
                pulse(12'(1) << i);
                rd(5'h00); check("R2 set", rd_s, 16'(1) << i);
                check("R3 irq on", {15'h0, irq_s}, 16'h1);
                rd(5'h10 + 5'(i)); check("R4 clear returns zero", rd_s, 16'h0);
                rd(5'h00); check("R4 cleared", rd_s, 16'h0);
                check("R3 irq off", {15'h0, irq_s}, 16'h0);
            end else begin
                // R6 level source: clear read while level high has no effect
                cyc(5'h10 + 5'(i), 1'b1, 1'b0, 16'h0, 12'(1) << i, 16'h0);
                cyc(5'h00, 1'b1, 1'b0, 16'h0, 12'(1) << i, 16'h0);
                check("R6 level held", rd_s, 16'(1) << i);
                cyc(5'h04, 1'b1, 1'b0, 16'h0, 12'(1) << i, 16'h0);
                cyc(5'h00, 1'b1, 1'b0, 16'h0, 12'(1) << i, 16'h0);
                check("R6 level after clear-all", rd_s, 16'(1) << i);
                rd(5'h00); check("R6 level dropped", rd_s, 16'h0);
            end
        end

        // R4 sweep: all sticky set, cleared one at a time
        pulse(STICKY);
        exp_raw = STICKY;
        for (int i = 0; i < 16; i++) begin
            rd(5'h10 + 5'(i));
            if (i < 12) exp_raw &= ~(12'(1) << i);
            rd(5'h00); check("R4 sweep", rd_s, {4'h0, exp_raw});
        end

        // R3 exhaustive mask sweep
        pulse(12'h5A1);
        for (int m = 0; m < 4096; m++) begin
            wr_mask(16'(m));
            rd(5'h01);
            check("R3 masked", rd_s, {4'h0, 12'h5A1 & 12'(m)});
            check("R3 irq", {15'h0, irq_s}, {15'h0, |(12'h5A1 & 12'(m))});
        end

        // R9 zero mask silences, raw intact; upper write bits dropped
        wr_mask(16'h0000);
        rd(5'h00); check("R9 raw intact", rd_s, 16'h05A1);
        check("R9 irq quiet", {15'h0, irq_s}, 16'h0);
        wr_mask(16'hFFFF);
        rd(5'h02); check("R9 mask width", rd_s, 16'h0FFF);
        check("R9 irq back", {15'h0, irq_s}, 16'h1);

        // R10 unmapped read and idle read data
        rd(5'h08); check("R10 unmapped", rd_s, 16'h0);
        rd(5'h1F); check("R10 unmapped hi", rd_s, 16'h0);
        cyc(5'h00, 1'b0, 1'b0, 16'h0, 12'h0, 16'h0);
        check("R10 idle rdata", rd_s, 16'h0);
        rd(5'h00); check("R10 no side effect", rd_s, 16'h05A1);

        // R5 combined clear
        cyc(5'h00, 1'b0, 1'b0, 16'h0, 12'h0, 16'h0483);
        rd(5'h04); check("R5 clear-all data", rd_s, 16'h0);
        rd(5'h00); check("R5 raw cleared", rd_s, 16'h0);
        rd(5'h03); check("R5 cause cleared", rd_s, 16'h0);

        // R7 cause capture per bit, filtering, abort clear
        for (int j = 0; j < 16; j++) begin
            cyc(5'h00, 1'b0, 1'b0, 16'h0, 12'h0, 16'(1) << j);
            rd(5'h00);
            rd(5'h03); check("R7 capture", rd_s, (16'(1) << j) & VALID);
            rd(5'h16);
            rd(5'h03); check("R7 abort clear", rd_s, 16'h0);
        end
        cyc(5'h00, 1'b0, 1'b0, 16'h0, 12'h0, 16'h0003);
        cyc(5'h00, 1'b0, 1'b0, 16'h0, 12'h0, 16'hF180);
        exp_c = (16'h0003 | 16'hF180) & VALID;
        rd(5'h15);   // other clear leaves cause
        rd(5'h03); check("R7 accumulate", rd_s, exp_c);

        // R8 same-cycle set and clear
        rd(5'h16);
        cyc(5'h10, 1'b1, 1'b0, 16'h0, 12'h001, 16'h0);
        rd(5'h00); check("R8 dedicated", rd_s, 16'h0001);
        pulse(12'h0C0);
        cyc(5'h04, 1'b1, 1'b0, 16'h0, 12'h200, 16'h0008);
        rd(5'h00); check("R8 clear-all keeps new", rd_s, 16'h0200);
        rd(5'h03); check("R8 cause kept", rd_s, 16'h0008);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule